// File: doc/BRIEF.md
# Interrupt Status, Clear and Mask Unit

This unit gathers the event indications produced by the command and data paths of a memory-card host controller into one 32-bit status word. Two kinds of bit share that word. Sticky event flags are set by a one-cycle pulse and stay set until software writes a one to the matching position of a write-one-to-clear register. Live flags mirror present conditions such as path activity, FIFO fill state and a busy data line, and no write can change them. Positions 29 to 31 are unimplemented.

An enable mask with the same bit layout as the status word picks the sticky flags that may raise the single interrupt request line. The line is a combinational OR over the enabled sticky flags, so it drops in the cycle a clear or a mask write lands. Software reaches the three registers through a small read/write port with a two-bit word select. Reads are combinational.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every sticky flag and every mask bit reads zero and `irq_o` is low.
- R2: An event pulse on a sticky position (bits 0 to 11 and 21 to 28; for example bit 0 is command CRC fail, bit 2 is command timeout and bit 8 is data end) sets that status bit one clock later, and the bit stays set without further pulses.
- R3: A write to the clear register (select 1) clears every sticky flag whose data bit is one and leaves the flags whose data bit is zero unchanged.
- R4: When an event pulse and a clear write hit the same sticky bit in the same cycle, the bit ends up set.
- R5: Status bits 12 to 20 equal `live_lvl_i` in the same cycle. Clear writes and event pulses have no effect on these positions.
- R6: Status bits 29 to 31 always read zero, whatever the event pulses.
- R7: The mask register (select 2) is written with the data word and reads back with bits 29 to 31 forced to zero.
- R8: `irq_o` is high exactly when some sticky flag is set and its mask bit is one. Live flags never raise it.
- R9: The card-interrupt event at bit 22 is a sticky flag and is enabled by mask bit 22.
- R10: Select 1 (clear) and select 3 read zero. Writes to select 0 (status) and select 3 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Word select: 0 status, 1 clear, 2 mask, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| evt_pulse_i | input | 32 | One-cycle event pulses, one per status position |
| live_lvl_i | input | 32 | Level conditions; only bits 12 to 20 are used |
| status_o | output | 32 | Current status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives a set pulse and a clear write on the same bit in the same cycle, and also clears a neighbouring bit in that cycle. If the clear won, the pending event would be lost silently. If the per-bit decode were wrong, the neighbouring bit would stay set. Clear writes aimed at the live positions, and event pulses on live and unimplemented positions, catch a design that latches or clears the wrong range. Such a design would show stale bits or keep a line that is still busy out of view. The interrupt checks enable every mask bit while only live flags are high, and they move the enable off a pending flag and back. This exposes an OR that takes in live flags, or a request line that is registered and so lags by one cycle.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CLEAR  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  // contiguous run of ones from lo to hi inclusive
  function automatic logic [63:0] bit_span(int lo, int hi);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/isu_rst_sync.sv
module isu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/isu_flag_bank.sv
module isu_flag_bank #(
  parameter int               W      = 32,
  parameter logic [W-1:0]     STICKY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] set_m, clr_m;
  logic [W-1:0] flag_q, flag_d, flag_en;

  assign set_m = set_i & STICKY;
  assign clr_m = clr_i & STICKY;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // set outranks clear in the same cycle
    always_comb begin
      flag_en[b] = set_m[b] | clr_m[b];
      flag_d[b]  = set_m[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[b] <= 1'b0;
      else if (flag_en[b]) flag_q[b] <= flag_d[b];
    end
  end

  assign flags_o = flag_q;

  a_r2_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_m) |=> ((flags_o & $past(set_m)) == $past(set_m)));

  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_m & clr_m)) |=> ((flags_o & $past(set_m & clr_m)) == $past(set_m & clr_m)));

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_m & ~set_m)) |=> ((flags_o & $past(clr_m & ~set_m)) == '0));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m == '0 && clr_m == '0) |=> $stable(flags_o));

  a_r6_unsticky_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~STICKY) == '0);
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = wdata_i & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mask_o == ($past(wdata_i) & IMPL)));

  a_r7_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_o));
endmodule

// File: rtl/isu_read_mux.sv
module isu_read_mux
  import irq_stat_pkg::*;
#(
  parameter int W = 32
) (
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      SEL_STATUS: rdata_o = status_i;
      SEL_MASK:   rdata_o = mask_i;
      default:    rdata_o = '0;
    endcase
  end

  always_comb begin
    if (sel_i == SEL_CLEAR)
      a_r10_clear_reads_zero: assert (rdata_o == '0);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LIVE_LO = 12,
  parameter int LIVE_HI = 20,
  parameter int IMPL_HI = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [WORD_W-1:0] evt_pulse_i,
  input  logic [WORD_W-1:0] live_lvl_i,
  output logic [WORD_W-1:0] status_o,
  output logic              irq_o
);
  localparam logic [WORD_W-1:0] IMPL_BITS   = WORD_W'(bit_span(0, IMPL_HI));
  localparam logic [WORD_W-1:0] LIVE_BITS   = WORD_W'(bit_span(LIVE_LO, LIVE_HI));
  localparam logic [WORD_W-1:0] STICKY_BITS = IMPL_BITS & ~LIVE_BITS;

  logic              rst_int_n;
  reg_sel_e          sel;
  logic              clr_wr, mask_wr;
  logic [WORD_W-1:0] clr_vec, flags, mask;

  isu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign sel     = reg_sel_e'(reg_sel);
  assign clr_wr  = reg_we && (sel == SEL_CLEAR);
  assign mask_wr = reg_we && (sel == SEL_MASK);
  assign clr_vec = clr_wr ? reg_wdata : '0;

  isu_flag_bank #(.W(WORD_W), .STICKY(STICKY_BITS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (evt_pulse_i),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  isu_mask_reg #(.W(WORD_W), .IMPL(IMPL_BITS)) u_mask (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en_i (mask_wr),
    .wdata_i (reg_wdata),
    .mask_o  (mask)
  );

  assign status_o = flags | (live_lvl_i & LIVE_BITS);
  assign irq_o    = |(flags & mask);

  isu_read_mux #(.W(WORD_W)) u_rd (
    .sel_i    (sel),
    .status_i (status_o),
    .mask_i   (mask),
    .rdata_o  (reg_rdata)
  );

  a_r8_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask == '0) |-> !irq_o);

  a_r8_live_never_irq: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((status_o & STICKY_BITS) == '0) |-> !irq_o);

  a_r6_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status_o & ~IMPL_BITS) == '0);
endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata, evt_pulse_i, live_lvl_i, status_o;
  logic        irq_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse_i(evt_pulse_i),
    .live_lvl_i(live_lvl_i), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    #1;
  endtask

  task automatic rd(logic [1:0] s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [31:0] v);
    @(negedge clk);
    evt_pulse_i = v;
    @(negedge clk);
    evt_pulse_i = '0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 status after reset", d, 32'h0);
    rd(2'd2, d); chk("R1 mask after reset", d, 32'h0);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_set();
    pulse(32'h0000_0105);
    chk("R2 flags 0,2,8 latched", status_o, 32'h0000_0105);
    pulse(32'h0040_0000);
    chk("R9 bit22 latched", status_o, 32'h0040_0105);
    repeat (3) @(negedge clk);
    chk("R2 flags hold", status_o, 32'h0040_0105);
  endtask

  task automatic t_clear();
    wr(2'd1, 32'h0000_0004);
    chk("R3 clear bit2 only", status_o, 32'h0040_0101);
    wr(2'd1, 32'h0000_0000);
    chk("R3 zero write no effect", status_o, 32'h0040_0101);
  endtask

  task automatic t_priority();
    @(negedge clk);
    evt_pulse_i = 32'h2;
    reg_sel = 2'd1; reg_wdata = 32'h3; reg_we = 1'b1;
    @(negedge clk);
    evt_pulse_i = '0; reg_we = 1'b0; reg_wdata = '0;
    #1;
    chk("R4 set wins, neighbour cleared", status_o, 32'h0040_0102);
  endtask

  task automatic t_live();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R3 clear all", status_o, 32'h0);
    @(negedge clk);
    live_lvl_i = 32'hFFFF_FFFF;
    #1;
    chk("R5 live bits follow input", status_o, 32'h001F_F000);
    wr(2'd1, 32'h001F_F000);
    rd(2'd0, d);
    chk("R5 live bits not clearable", d, 32'h001F_F000);
    @(negedge clk);
    live_lvl_i = '0;
    #1;
    chk("R5 live bits drop with input", status_o, 32'h0);
    pulse(32'h001F_F000);
    chk("R5 pulses on live bits ignored", status_o, 32'h0);
  endtask

  task automatic t_reserved();
    pulse(32'hE000_0000);
    chk("R6 reserved pulses ignored", status_o, 32'h0);
    pulse(32'hFFFF_FFFF);
    chk("R6 only sticky bits latch", status_o, 32'h1FE0_0FFF);
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R3 clear all sticky", status_o, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R7 mask readback", d, 32'h1FFF_FFFF);
    @(negedge clk);
    live_lvl_i = 32'h001F_F000;
    #1;
    chk("R8 live flags no irq", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    live_lvl_i = '0;
    wr(2'd2, 32'h0040_0000);
    pulse(32'h1);
    chk("R8 disabled flag no irq", {31'h0, irq_o}, 32'h0);
    pulse(32'h0040_0000);
    chk("R9 bit22 enabled raises irq", {31'h0, irq_o}, 32'h1);
    wr(2'd1, 32'h0040_0000);
    chk("R8 irq drops on clear", {31'h0, irq_o}, 32'h0);
    chk("R3 other flag kept", status_o, 32'h1);
    wr(2'd2, 32'h1);
    chk("R8 irq on mask enable", {31'h0, irq_o}, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0);
    chk("R8 irq low after cleanup", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    pulse(32'h8);
    wr(2'd0, 32'h0);
    chk("R10 status write ignored", status_o, 32'h8);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R10 spare write leaves mask", d, 32'h0);
    chk("R10 spare write leaves status", status_o, 32'h8);
    rd(2'd1, d); chk("R10 clear reads zero", d, 32'h0);
    rd(2'd3, d); chk("R10 spare reads zero", d, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    evt_pulse_i = '0; live_lvl_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_priority();
    t_live();
    t_reserved();
    t_mask();
    t_readonly();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule